// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset request on the chip into one reset and times its release. Five kinds of request reach it: power-on, watchdog overflow, illegal opcode, an opcode fetch from unmapped space, and a low-voltage detect. Each request is first checked against its own condition, either a configuration enable bit or the kind of bus cycle. A request that passes is recorded as the cause of the reset and starts a stretch sequence.

The sequence has two stages. An active-low external reset pin is held low first. For power-on and low-voltage resets this stage lasts until the synchronized supply-good input has been high for a long count. For internal sources it is a short count. The pin is then released while the CPU is kept in reset for a further hold count. When the CPU reset drops, a one-cycle flag marks the start of the reset-vector fetch.

A five-bit cause register, `statusOut`, tells software why the last reset happened. Its bits are power-on in bit 0, low-voltage in bit 1, illegal address in bit 2, illegal opcode in bit 3 and watchdog in bit 4.

Top module: `rstseq_top`

## Requirements
- R1: While `porIn` is high, `extRstN` is 0, `cpuRst` is 1, `vecFetch` is 0 and `statusOut` is 5'b00001.
- R2: `supplyOkIn` passes through a two-flop synchronizer. In a long stretch, `extRstN` stays low until the synchronized supply has been high for LONG_CYC (4096) consecutive cycles. After `porIn` falls with the supply already good, this gives 4097 low samples. While the synchronized supply is low, the count stays at zero.
- R3: After a stretch, `extRstN` goes high while `cpuRst` stays high for HOLD_CYC (64) cycles. On the first cycle with `cpuRst` low, `vecFetch` is 1 for exactly one cycle.
- R4: `wdogOvf` causes a reset and loads 5'b10000 only when `cfgWdogDis` is 0. Otherwise it has no effect.
- R5: `illegalOp` causes a reset and loads 5'b01000. `stopExec` acts the same way when `cfgStopEn` is 0 and is ignored when `cfgStopEn` is 1.
- R6: `unmappedAcc` causes a reset and loads 5'b00100 only when `opcodeFetch` is 1. A data access to unmapped space does nothing.
- R7: `lviDetect` starts a long stretch and loads 5'b00010 only when both `cfgLviPwrDn` and `cfgLviRstDis` are 0.
- R8: An internal request (watchdog, illegal opcode, illegal address) sampled at a clock edge gives SHORT_CYC (32) low cycles on `extRstN`, starting from that edge, followed by the hold stage of R3.
- R9: The cause register is sticky. An accepted request replaces it with the bits of every source accepted in that same cycle. An ignored request leaves it unchanged.
- R10: An accepted request during any stretch restarts the timing from zero. An internal request starts a short stretch, unless a long stretch is already running, in which case the long stretch restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| porIn | input | 1 | Power-on reset, asynchronous, active high |
| supplyOkIn | input | 1 | Supply-good level, asynchronous to `clk` |
| wdogOvf | input | 1 | Watchdog counter overflow |
| illegalOp | input | 1 | CPU reports an illegal opcode |
| stopExec | input | 1 | CPU executes a STOP instruction |
| unmappedAcc | input | 1 | Current access targets unmapped space |
| opcodeFetch | input | 1 | Current access is an opcode fetch |
| lviDetect | input | 1 | Low-voltage comparator output |
| cfgWdogDis | input | 1 | Watchdog reset disable |
| cfgStopEn | input | 1 | STOP instruction enable |
| cfgLviPwrDn | input | 1 | Low-voltage detector powered down |
| cfgLviRstDis | input | 1 | Low-voltage reset disable |
| extRstN | output | 1 | External reset pin drive, active low |
| cpuRst | output | 1 | CPU reset, active high |
| vecFetch | output | 1 | One-cycle pulse marking the start of the reset-vector fetch |
| statusOut | output | 5 | Sticky reset cause bits |

## Verification
A wrong state or count value shows up at the pins as a stretch of the wrong length. The error appears as soon as `extRstN` rises or `cpuRst` falls: within 32 cycles for an internal reset, and about 4100 cycles for a supply-related reset. A qualification fault is visible one cycle after the request, as a `cpuRst` that should or should not be set and as a changed or unchanged `statusOut`. A lost restart is seen as a low phase cut short after the second request.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int CAUSE_W = 5;
  localparam int CB_POR  = 0;
  localparam int CB_LVI  = 1;
  localparam int CB_ILAD = 2;
  localparam int CB_ILOP = 3;
  localparam int CB_WDOG = 4;

  typedef enum logic [1:0] {ST_RUN, ST_LONG, ST_SHORT, ST_HOLD} seqState_t;

  typedef struct packed {
    logic               cntClr;
    logic               cntInc;
    logic               causeLoad;
    logic [CAUSE_W-1:0] cause;
  } seqStrobe_t;
endpackage

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               supplyOkIn,
  input  seqStrobe_t         strobe,
  output logic [CNT_W-1:0]   cntVal,
  output logic               supplyOkSync,
  output logic [CAUSE_W-1:0] causeStatus
);
  logic [1:0] syncQ;

  // two-flop synchronizer for the supply-good level
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) syncQ <= '0;
    else       syncQ <= {syncQ[0], supplyOkIn};
  end
  assign supplyOkSync = syncQ[1];

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)              cntVal <= '0;
    else if (strobe.cntClr) cntVal <= '0;
    else if (strobe.cntInc) cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)                 causeStatus <= CAUSE_W'(1) << CB_POR;
    else if (strobe.causeLoad) causeStatus <= strobe.cause;
  end

  // R2: synchronized level rises two samples after the raw input was high
  a_r2_sync_latency: assert property (@(posedge clk) disable iff (porIn)
    $rose(supplyOkSync) |-> $past(supplyOkIn, 2));

  // R9: a cause load never leaves the register empty
  a_r9_cause_nonzero: assert property (@(posedge clk) disable iff (porIn)
    strobe.causeLoad |=> (causeStatus != '0));
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32,
  parameter int HOLD_CYC  = 64,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             porIn,
  input  logic             wdogOvf,
  input  logic             illegalOp,
  input  logic             stopExec,
  input  logic             unmappedAcc,
  input  logic             opcodeFetch,
  input  logic             lviDetect,
  input  logic             cfgWdogDis,
  input  logic             cfgStopEn,
  input  logic             cfgLviPwrDn,
  input  logic             cfgLviRstDis,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             supplyOkSync,
  output seqStrobe_t       strobe,
  output logic             extRstN,
  output logic             cpuRst,
  output logic             vecFetch
);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(HOLD_CYC - 1);

  seqState_t state, nextState;
  logic wdQual, ilopQual, iladQual, lviQual, intReq;
  logic [CAUSE_W-1:0] causeVec;

  // per-source qualification
  always_comb begin
    wdQual   = wdogOvf & ~cfgWdogDis;
    ilopQual = illegalOp | (stopExec & ~cfgStopEn);
    iladQual = unmappedAcc & opcodeFetch;
    lviQual  = lviDetect & ~cfgLviPwrDn & ~cfgLviRstDis;
    intReq   = wdQual | ilopQual | iladQual;
    causeVec = '0;
    causeVec[CB_WDOG] = wdQual;
    causeVec[CB_ILOP] = ilopQual;
    causeVec[CB_ILAD] = iladQual;
    causeVec[CB_LVI]  = lviQual;
  end

  always_comb begin
    nextState        = state;
    strobe.cntClr    = 1'b0;
    strobe.cntInc    = 1'b0;
    strobe.causeLoad = intReq | lviQual;
    strobe.cause     = causeVec;
    if (lviQual) begin
      nextState     = ST_LONG;
      strobe.cntClr = 1'b1;
    end else if (intReq) begin
      nextState     = (state == ST_LONG) ? ST_LONG : ST_SHORT;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_LONG: begin
          if (!supplyOkSync) strobe.cntClr = 1'b1;
          else if (cntVal == LONG_END) begin
            nextState     = ST_HOLD;
            strobe.cntClr = 1'b1;
          end else strobe.cntInc = 1'b1;
        end
        ST_SHORT: begin
          if (cntVal == SHORT_END) begin
            nextState     = ST_HOLD;
            strobe.cntClr = 1'b1;
          end else strobe.cntInc = 1'b1;
        end
        ST_HOLD: begin
          if (cntVal == HOLD_END) begin
            nextState     = ST_RUN;
            strobe.cntClr = 1'b1;
          end else strobe.cntInc = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      state    <= ST_LONG;
      vecFetch <= 1'b0;
    end else begin
      state    <= nextState;
      vecFetch <= (state == ST_HOLD) && (nextState == ST_RUN);
    end
  end

  assign extRstN = (state == ST_RUN) || (state == ST_HOLD);
  assign cpuRst  = (state != ST_RUN);

  // R3: pin is released while the CPU is still held
  a_r3_pin_before_cpu: assert property (@(posedge clk) disable iff (porIn)
    $rose(extRstN) |-> cpuRst);

  // R3: vector flag only on the cycle the CPU leaves reset
  a_r3_vec_on_release: assert property (@(posedge clk) disable iff (porIn)
    vecFetch |-> (!cpuRst && $past(cpuRst)));

  // R6: data access to unmapped space alone never resets a running CPU
  a_r6_data_access_ignored: assert property (@(posedge clk) disable iff (porIn)
    (!cpuRst && unmappedAcc && !opcodeFetch && !wdogOvf && !illegalOp
     && !stopExec && !lviDetect) |=> !cpuRst);

  // R2: no release of the pin while the synchronized supply is low
  a_r2_wait_supply: assert property (@(posedge clk) disable iff (porIn)
    (state == ST_LONG && !supplyOkSync) |=> !extRstN);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32,
  parameter int HOLD_CYC  = 64
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               supplyOkIn,
  input  logic               wdogOvf,
  input  logic               illegalOp,
  input  logic               stopExec,
  input  logic               unmappedAcc,
  input  logic               opcodeFetch,
  input  logic               lviDetect,
  input  logic               cfgWdogDis,
  input  logic               cfgStopEn,
  input  logic               cfgLviPwrDn,
  input  logic               cfgLviRstDis,
  output logic               extRstN,
  output logic               cpuRst,
  output logic               vecFetch,
  output logic [CAUSE_W-1:0] statusOut
);
  localparam int MAX_A  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int MAX_C  = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W  = (MAX_C > 2) ? $clog2(MAX_C) : 1;

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic             supplyOkSync;

  rstseq_ctrl #(
    .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC), .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .porIn(porIn),
    .wdogOvf(wdogOvf), .illegalOp(illegalOp), .stopExec(stopExec),
    .unmappedAcc(unmappedAcc), .opcodeFetch(opcodeFetch), .lviDetect(lviDetect),
    .cfgWdogDis(cfgWdogDis), .cfgStopEn(cfgStopEn),
    .cfgLviPwrDn(cfgLviPwrDn), .cfgLviRstDis(cfgLviRstDis),
    .cntVal(cntVal), .supplyOkSync(supplyOkSync), .strobe(strobe),
    .extRstN(extRstN), .cpuRst(cpuRst), .vecFetch(vecFetch)
  );

  rstseq_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .porIn(porIn), .supplyOkIn(supplyOkIn), .strobe(strobe),
    .cntVal(cntVal), .supplyOkSync(supplyOkSync), .causeStatus(statusOut)
  );

  // R4: a masked watchdog overflow alone leaves the causes untouched
  a_r4_wdog_masked: assert property (@(posedge clk) disable iff (porIn)
    (cfgWdogDis && wdogOvf && !illegalOp && !stopExec && !unmappedAcc && !lviDetect)
    |=> $stable(statusOut));
endmodule

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;
  localparam int LONG_CYC  = 4096;
  localparam int SHORT_CYC = 32;
  localparam int HOLD_CYC  = 64;
  localparam int NVEC      = 10;
  // {wd, ilop, stop, unm, opf, lvi, cfgWd, cfgStop, cfgLpd, cfgLrd, expRst, expStatus[4:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {10'b1000000100, 1'b1, 5'b10000},
    {10'b1000001100, 1'b0, 5'b10000},
    {10'b0100000100, 1'b1, 5'b01000},
    {10'b0010000100, 1'b0, 5'b01000},
    {10'b0010000000, 1'b1, 5'b01000},
    {10'b0001100100, 1'b1, 5'b00100},
    {10'b0001000100, 1'b0, 5'b00100},
    {10'b1100000100, 1'b1, 5'b11000},
    {10'b0000010110, 1'b0, 5'b11000},
    {10'b0000010101, 1'b0, 5'b11000}
  };

  logic clk = 1'b0;
  logic porIn, supplyOkIn;
  logic wdogOvf, illegalOp, stopExec, unmappedAcc, opcodeFetch, lviDetect;
  logic cfgWdogDis, cfgStopEn, cfgLviPwrDn, cfgLviRstDis;
  logic extRstN, cpuRst, vecFetch;
  logic [4:0] statusOut;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rstseq_top dut_i (
    .clk(clk), .porIn(porIn), .supplyOkIn(supplyOkIn),
    .wdogOvf(wdogOvf), .illegalOp(illegalOp), .stopExec(stopExec),
    .unmappedAcc(unmappedAcc), .opcodeFetch(opcodeFetch), .lviDetect(lviDetect),
    .cfgWdogDis(cfgWdogDis), .cfgStopEn(cfgStopEn),
    .cfgLviPwrDn(cfgLviPwrDn), .cfgLviRstDis(cfgLviRstDis),
    .extRstN(extRstN), .cpuRst(cpuRst), .vecFetch(vecFetch), .statusOut(statusOut)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // counts the current and following samples with the pin low
  task automatic countLow(output int n);
    n = 0;
    while (!extRstN && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // counts the current and following samples of the hold stage
  task automatic countHold(output int n);
    n = 0;
    while (extRstN && cpuRst && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clearReqs();
    wdogOvf = 0; illegalOp = 0; stopExec = 0; unmappedAcc = 0;
    opcodeFetch = 0; lviDetect = 0;
  endtask

  task automatic waitRun();
    for (int i = 0; i < 300 && cpuRst; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finishRun();
      end
    end
  end

  initial begin
    int n;
    clearReqs();
    cfgWdogDis = 0; cfgStopEn = 1; cfgLviPwrDn = 0; cfgLviRstDis = 0;
    porIn = 1; supplyOkIn = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(extRstN == 0, "R1 pin low in reset", extRstN, 0);
    check(cpuRst == 1, "R1 cpu held in reset", cpuRst, 1);
    check(statusOut == 5'b00001, "R1 status power-on only", statusOut, 1);
    check(vecFetch == 0, "R1 no vector flag", vecFetch, 0);

    // R2/R3 power-on recovery
    porIn = 0;
    @(negedge clk);
    countLow(n);
    check(n == LONG_CYC + 1, "R2 long stretch length", n, LONG_CYC + 1);
    countHold(n);
    check(n == HOLD_CYC, "R3 cpu hold after pin release", n, HOLD_CYC);
    check(vecFetch == 1, "R3 vector flag on release", vecFetch, 1);
    @(negedge clk);
    check(vecFetch == 0, "R3 vector flag single cycle", vecFetch, 0);

    // vector table: R4 R5 R6 R7 R9 qualification
    for (int v = 0; v < NVEC; v++) begin
      {wdogOvf, illegalOp, stopExec, unmappedAcc, opcodeFetch, lviDetect,
       cfgWdogDis, cfgStopEn, cfgLviPwrDn, cfgLviRstDis} = VEC[v][15:6];
      @(negedge clk);
      clearReqs();
      check(cpuRst == VEC[v][5], $sformatf("R4/R5/R6/R7 vector %0d reset", v),
            cpuRst, VEC[v][5]);
      check(statusOut == VEC[v][4:0], $sformatf("R9 vector %0d cause", v),
            statusOut, VEC[v][4:0]);
      if (!VEC[v][5])
        check(extRstN == 1, $sformatf("R7 vector %0d pin untouched", v), extRstN, 1);
      else waitRun();
    end
    cfgWdogDis = 0; cfgStopEn = 1; cfgLviPwrDn = 0; cfgLviRstDis = 0;

    // R8 internal stretch timing
    wdogOvf = 1;
    @(negedge clk);
    clearReqs();
    countLow(n);
    check(n == SHORT_CYC, "R8 short stretch length", n, SHORT_CYC);
    countHold(n);
    check(n == HOLD_CYC, "R8 hold after short stretch", n, HOLD_CYC);
    check(vecFetch == 1, "R8 vector flag", vecFetch, 1);
    @(negedge clk);

    // R10 restart during hold
    wdogOvf = 1;
    @(negedge clk);
    clearReqs();
    countLow(n);
    repeat (10) @(negedge clk);
    illegalOp = 1;
    @(negedge clk);
    clearReqs();
    check(extRstN == 0, "R10 pin pulled low again", extRstN, 0);
    countLow(n);
    check(n == SHORT_CYC, "R10 restarted stretch length", n, SHORT_CYC);
    check(statusOut == 5'b01000, "R10 cause replaced", statusOut, 8);
    waitRun();

    // R7 low-voltage reset waits for supply
    supplyOkIn = 0; lviDetect = 1;
    @(negedge clk);
    clearReqs();
    check(statusOut == 5'b00010, "R7 low-voltage cause", statusOut, 2);
    repeat (5000) @(negedge clk);
    check(extRstN == 0, "R2 pin held without supply", extRstN, 0);
    supplyOkIn = 1;
    @(negedge clk);
    countLow(n);
    check(n == LONG_CYC + 1, "R7 long stretch after supply good", n, LONG_CYC + 1);
    countHold(n);
    check(n == HOLD_CYC, "R3 hold after low-voltage stretch", n, HOLD_CYC);

    // R1 power-on clears other causes
    porIn = 1;
    @(negedge clk);
    check(statusOut == 5'b00001, "R1 power-on clears causes", statusOut, 1);
    check(cpuRst == 1, "R1 cpu reset on power-on", cpuRst, 1);
    finishRun();
  end
endmodule